// File: doc/BRIEF.md
# Nine-Bit Serial Port with Timer-Driven Bit Rate

This block is a full-duplex asynchronous serial port that carries eleven-bit frames. Each frame holds a low start bit, eight data bits sent least significant bit first, a ninth bit chosen by software, and a high stop bit. The port does not generate its own bit rate. An 8-bit auto-reload timer outside the block pulses `tmrOvf` once per overflow. The port turns those pulses into sixteen sample ticks per bit, so a bit lasts 32 overflows at the normal rate and 16 overflows when `dblRate` is set. With an 11.0592 MHz oscillator and a reload value that gives 38400 overflows per second, the normal rate is 1200 baud.

Software starts a transmission by pulsing `dataWr` with the byte on `dataIn` and the ninth bit on `txBit9`. The receiver runs while `rxEnable` is high. It finds a falling start edge, takes three samples around the middle of each bit and keeps the majority value, then places the byte and the ninth bit on `rxData` and `rxBit9`. Completion flags for each direction stay set until software clears them with a one-cycle pulse.

Top module: `uart9_top`

## Requirements
- R1: After reset `txLine` is high, `txFlag`, `rxFlag` and `rxBit9` are 0 and `rxData` is 0x00. While no frame is being sent, `txLine` stays high.
- R2: A `dataWr` pulse while the transmitter is idle sends a frame on `txLine` in this order: start bit 0, then `dataIn` bit 0 through bit 7, then the value `txBit9` had at the write, then stop bit 1.
- R3: One bit lasts 16 sample ticks. A sample tick comes every second `tmrOvf` pulse when `dblRate` is 0 and on every pulse when it is 1. This applies to both transmit and receive.
- R4: `txFlag` goes to 1 in the cycle the stop bit starts on `txLine`. It is 0 during the ninth bit if it was cleared before the frame.
- R5: A `dataWr` pulse while a frame is being sent is ignored. The frame in progress is unchanged and no extra frame follows it.
- R6: A falling edge on `rxLine` with `rxEnable` high starts a reception. The nine received bits go to `rxData` (first data bit in bit 0) and `rxBit9`, and `rxFlag` is set once the stop bit has been sampled high.
- R7: If the start bit reads high at its middle, the receiver treats it as a false start. It returns to idle without setting `rxFlag`, and a later frame is received normally.
- R8: While `rxEnable` is 0, frames on `rxLine` leave `rxFlag`, `rxData` and `rxBit9` unchanged.
- R9: A frame whose stop bit reads low, or one that ends while `rxFlag` is still 1, is dropped. `rxData` and `rxBit9` keep their earlier values.
- R10: Each flag stays 1 until its clear input (`txFlagClr` or `rxFlagClr`) is pulsed. A set in the same cycle as a clear wins.
- R11: Each received bit is the majority of three samples taken at the 8th, 9th and 10th sample ticks of the bit. A disturbance on `rxLine` that lasts one tick period near the middle of a bit does not change the received value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrOvf | input | 1 | One-cycle pulse on each overflow of the external timer |
| dblRate | input | 1 | 1 doubles the bit rate (16 overflows per bit instead of 32) |
| rxEnable | input | 1 | Allows new receptions to start |
| dataWr | input | 1 | Write strobe that starts a transmission |
| dataIn | input | 8 | Byte to transmit |
| txBit9 | input | 1 | Ninth bit to transmit, taken at the write |
| txFlagClr | input | 1 | Clears `txFlag` |
| rxFlagClr | input | 1 | Clears `rxFlag` |
| rxLine | input | 1 | Serial input, asynchronous |
| txLine | output | 1 | Serial output |
| rxData | output | 8 | Last accepted received byte |
| rxBit9 | output | 1 | Ninth bit of the last accepted frame |
| txFlag | output | 1 | Transmit-complete flag |
| rxFlag | output | 1 | Receive-complete flag |

## Verification
Most internal faults appear at the ports within one frame. If the transmit sub-bit counter or the bit index is wrong, the point where `txFlag` rises moves away from ten bit periods after the start edge, and the data bits are sampled from the wrong positions. A receiver stuck out of idle shows up one frame later, as a missing `rxFlag` or a stale `rxData`. A vote window in the wrong place shows up as a bit that a one-tick glitch flips. A flag-priority error shows up at the first clear pulse, or at the first frame that arrives while `rxFlag` is still set.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  // One-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic txLoad;        // capture byte and ninth bit, drive start bit
    logic txAdvance;     // move to the next frame bit
    logic txSetFlag;     // stop bit begins
    logic rxTakeSample;  // shift one line sample into the vote window
    logic rxPushBit;     // store the voted bit into the receive shifter
    logic rxCommit;      // publish received frame and raise the flag
  } uartStrobes_t;

endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tmrOvf,
  input  logic dblRate,
  output logic sampleTick
);

  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  generate
    if (SLOW_DIV > 1) begin : g_prescale
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOW_DIV - 1);
      logic [CNT_W-1:0] ovfCnt;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ovfCnt <= '0;
        end else if (tmrOvf) begin
          ovfCnt <= (ovfCnt == CNT_LAST) ? '0 : ovfCnt + 1'b1;
        end
      end

      assign sampleTick = tmrOvf && (dblRate || (ovfCnt == CNT_LAST));
    end else begin : g_direct
      logic unusedDbl;
      assign unusedDbl  = dblRate;
      assign sampleTick = tmrOvf;
    end
  endgenerate

endmodule

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleTick,
  input  logic         dataWr,
  input  logic         rxEnable,
  input  logic         rxFell,
  input  logic         voteBit,
  input  logic         rxFlag,
  output uartStrobes_t strb,
  output logic         txBusy,
  output logic         rxBusy
);

  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int SUB_W      = $clog2(OVS);

  localparam logic [IDX_W-1:0] STOP_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] BIT9_IDX  = IDX_W'(FRAME_BITS - 2);
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SAMP_A    = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SAMP_B    = SUB_W'(OVS / 2);
  localparam logic [SUB_W-1:0] SAMP_C    = SUB_W'(OVS / 2 + 1);
  localparam logic [SUB_W-1:0] DECIDE    = SUB_W'(OVS / 2 + 2);

  // ---------------- transmit sequencer ----------------
  logic [SUB_W-1:0] txSub;
  logic [IDX_W-1:0] txIdx;
  logic             txBitEnd;

  assign txBitEnd = txBusy && sampleTick && (txSub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txSub  <= '0;
      txIdx  <= '0;
    end else if (!txBusy) begin
      if (dataWr) begin
        txBusy <= 1'b1;
        txSub  <= '0;
        txIdx  <= '0;
      end
    end else if (sampleTick) begin
      if (txSub == SUB_LAST) begin
        txSub <= '0;
        if (txIdx == STOP_IDX) txBusy <= 1'b0;
        else                   txIdx  <= txIdx + 1'b1;
      end else begin
        txSub <= txSub + 1'b1;
      end
    end
  end

  // ---------------- receive sequencer ----------------
  logic [SUB_W-1:0] rxSub;
  logic [IDX_W-1:0] rxIdx;
  logic             rxTick;
  logic             rxDecide;
  logic             rxAbort;

  assign rxTick   = rxBusy && sampleTick;
  assign rxDecide = rxTick && (rxSub == DECIDE);
  assign rxAbort  = rxDecide && (((rxIdx == '0) && voteBit) || (rxIdx == STOP_IDX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxSub  <= '0;
      rxIdx  <= '0;
    end else if (!rxBusy) begin
      if (rxEnable && rxFell) begin
        rxBusy <= 1'b1;
        rxSub  <= '0;
        rxIdx  <= '0;
      end
    end else if (rxAbort) begin
      rxBusy <= 1'b0;
    end else if (rxTick) begin
      if (rxSub == SUB_LAST) begin
        rxSub <= '0;
        rxIdx <= rxIdx + 1'b1;
      end else begin
        rxSub <= rxSub + 1'b1;
      end
    end
  end

  // ---------------- strobes ----------------
  always_comb begin
    strb              = '0;
    strb.txLoad       = !txBusy && dataWr;
    strb.txAdvance    = txBitEnd && (txIdx != STOP_IDX);
    strb.txSetFlag    = txBitEnd && (txIdx == BIT9_IDX);
    strb.rxTakeSample = rxTick && ((rxSub == SAMP_A) || (rxSub == SAMP_B) || (rxSub == SAMP_C));
    strb.rxPushBit    = rxDecide && (rxIdx != '0) && (rxIdx != STOP_IDX);
    strb.rxCommit     = rxDecide && (rxIdx == STOP_IDX) && voteBit && !rxFlag;
  end

endmodule

// File: rtl/uart9_dp.sv
module uart9_dp
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uartStrobes_t      strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              txBit9,
  input  logic              txFlagClr,
  input  logic              rxFlagClr,
  input  logic              rxLine,
  output logic              txLine,
  output logic              rxFell,
  output logic              voteBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              txFlag,
  output logic              rxFlag
);

  localparam int FRAME_BITS = DATA_W + 3;

  // ---------------- transmit shifter ----------------
  logic [FRAME_BITS-1:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strb.txLoad) begin
      txShift <= {1'b1, txBit9, dataIn, 1'b0};
    end else if (strb.txAdvance) begin
      txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
    end
  end

  assign txLine = txShift[0];

  // ---------------- receive front end ----------------
  logic [2:0] rxSync;
  logic [2:0] voteWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= '1;
      voteWin <= '1;
    end else begin
      rxSync <= {rxSync[1:0], rxLine};
      if (strb.rxTakeSample) voteWin <= {voteWin[1:0], rxSync[1]};
    end
  end

  assign rxFell  = rxSync[2] && !rxSync[1];
  assign voteBit = (voteWin[0] && voteWin[1]) || (voteWin[0] && voteWin[2]) ||
                   (voteWin[1] && voteWin[2]);

  // ---------------- receive shifter and holding register ----------------
  logic [DATA_W:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxBit9  <= 1'b0;
    end else begin
      if (strb.rxPushBit) rxShift <= {voteBit, rxShift[DATA_W:1]};
      if (strb.rxCommit) begin
        rxData <= rxShift[DATA_W-1:0];
        rxBit9 <= rxShift[DATA_W];
      end
    end
  end

  // ---------------- flags: set beats clear ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFlag <= 1'b0;
      rxFlag <= 1'b0;
    end else begin
      if (strb.txSetFlag)  txFlag <= 1'b1;
      else if (txFlagClr)  txFlag <= 1'b0;
      if (strb.rxCommit)   rxFlag <= 1'b1;
      else if (rxFlagClr)  rxFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/uart9_top.sv
module uart9_top
  import uart9_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int SLOW_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrOvf,
  input  logic              dblRate,
  input  logic              rxEnable,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              txBit9,
  input  logic              txFlagClr,
  input  logic              rxFlagClr,
  input  logic              rxLine,
  output logic              txLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              txFlag,
  output logic              rxFlag
);

  uartStrobes_t strb;
  logic         sampleTick;
  logic         rxFell;
  logic         voteBit;
  logic         txBusy;
  logic         rxBusy;

  uart9_baud #(.SLOW_DIV(SLOW_DIV)) u_baud (
    .clk        (clk),
    .rstN       (rstN),
    .tmrOvf     (tmrOvf),
    .dblRate    (dblRate),
    .sampleTick (sampleTick)
  );

  uart9_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .dataWr     (dataWr),
    .rxEnable   (rxEnable),
    .rxFell     (rxFell),
    .voteBit    (voteBit),
    .rxFlag     (rxFlag),
    .strb       (strb),
    .txBusy     (txBusy),
    .rxBusy     (rxBusy)
  );

  uart9_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataIn    (dataIn),
    .txBit9    (txBit9),
    .txFlagClr (txFlagClr),
    .rxFlagClr (rxFlagClr),
    .rxLine    (rxLine),
    .txLine    (txLine),
    .rxFell    (rxFell),
    .voteBit   (voteBit),
    .rxData    (rxData),
    .rxBit9    (rxBit9),
    .txFlag    (txFlag),
    .rxFlag    (rxFlag)
  );

endmodule

// File: rtl/uart9_chk.sv
module uart9_chk
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input uartStrobes_t      strb,
  input logic              txBusy,
  input logic              rxBusy,
  input logic              txLine,
  input logic              txFlag,
  input logic              txFlagClr,
  input logic              rxFlag,
  input logic              rxFlagClr,
  input logic              rxEnable,
  input logic [DATA_W-1:0] rxData
);

  // R1: line rests high whenever no frame is in flight
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  // R4: the transmit flag rises exactly as the stop bit is driven
  a_r4_flag_at_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFlag) |-> (txLine && txBusy));

  // R10: flags hold until cleared
  a_r10_tx_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (txFlag && !txFlagClr) |=> txFlag);

  a_r10_rx_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !rxFlagClr) |=> rxFlag);

  // R9: a pending receive flag protects the held byte
  a_r9_data_held_while_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !rxFlagClr) |=> $stable(rxData));

  // R6: the held byte changes only through a commit
  a_r6_data_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxCommit |=> $stable(rxData));

  // R8: a disabled receiver never leaves idle
  a_r8_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !rxBusy) |=> !rxBusy);

endmodule

bind uart9_top uart9_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .txBusy    (txBusy),
  .rxBusy    (rxBusy),
  .txLine    (txLine),
  .txFlag    (txFlag),
  .txFlagClr (txFlagClr),
  .rxFlag    (rxFlag),
  .rxFlagClr (rxFlagClr),
  .rxEnable  (rxEnable),
  .rxData    (rxData)
);

// File: tb/uart9_top_tb.sv
module uart9_top_tb;

  localparam int CLK_PER = 10;
  localparam int OVF_PER = 4;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tmrOvf = 1'b0;
  logic       dblRate = 1'b0;
  logic       rxEnable = 1'b0;
  logic       dataWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       txBit9 = 1'b0;
  logic       txFlagClr = 1'b0;
  logic       rxFlagClr = 1'b0;
  logic       rxLine = 1'b1;
  logic       txLine;
  logic [7:0] rxData;
  logic       rxBit9;
  logic       txFlag;
  logic       rxFlag;

  int checks = 0;
  int errors = 0;
  int tickCyc = 2 * OVF_PER;
  int bitCyc  = 32 * OVF_PER;
  int framesSeen = 0;
  logic [8:0] txQ[$];

  uart9_top u_dut (
    .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .dblRate(dblRate),
    .rxEnable(rxEnable), .dataWr(dataWr), .dataIn(dataIn), .txBit9(txBit9),
    .txFlagClr(txFlagClr), .rxFlagClr(rxFlagClr), .rxLine(rxLine),
    .txLine(txLine), .rxData(rxData), .rxBit9(rxBit9),
    .txFlag(txFlag), .rxFlag(rxFlag)
  );

  initial forever #(CLK_PER / 2) clk = ~clk;

  // external timer: one overflow pulse every OVF_PER cycles
  initial begin
    forever begin
      repeat (OVF_PER - 1) @(negedge clk);
      tmrOvf = 1'b1;
      @(negedge clk);
      tmrOvf = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic setRate(input logic dbl);
    dblRate = dbl;
    tickCyc = dbl ? OVF_PER : 2 * OVF_PER;
    bitCyc  = 16 * tickCyc;
    repeat (4 * bitCyc) @(negedge clk);
  endtask

  // driver: push expected frame, write, optionally write again mid-frame
  task automatic sendTx(input logic [7:0] d, input logic b9, input bit extraWrite);
    txQ.push_back({b9, d});
    @(negedge clk);
    dataIn = d; txBit9 = b9; dataWr = 1'b1;
    @(negedge clk);
    dataWr = 1'b0; dataIn = ~d; txBit9 = ~b9;
    if (extraWrite) begin
      repeat (3 * bitCyc) @(negedge clk);
      dataWr = 1'b1;                       // R5: must be ignored
      @(negedge clk);
      dataWr = 1'b0;
    end
    repeat (12 * bitCyc) @(negedge clk);
    check("R4 txFlag set after frame", int'(txFlag), 1);
    repeat (50) @(negedge clk);
    check("R10 txFlag holds", int'(txFlag), 1);
    txFlagClr = 1'b1;
    @(negedge clk);
    txFlagClr = 1'b0;
    @(negedge clk);
    check("R10 txFlag cleared", int'(txFlag), 0);
  endtask

  // monitor: decode frames on txLine and compare with the queue
  initial begin
    logic [10:0] fr;
    int off;
    wait (rstN === 1'b1);
    forever begin
      @(negedge clk);
      if (txLine === 1'b0) begin
        off = 0;
        for (int i = 0; i < 10; i++) begin
          while (off < i * bitCyc + bitCyc / 2 - tickCyc / 2) begin
            @(negedge clk);
            off++;
          end
          fr[i] = txLine;
          if (i == 9) check("R4 txFlag low during ninth bit", int'(txFlag), 0);
        end
        while (txFlag !== 1'b1 && off < 12 * bitCyc) begin
          @(negedge clk);
          off++;
        end
        checkRange("R3 stop-bit start offset", off, 10 * bitCyc - tickCyc, 10 * bitCyc + 1);
        check("R4 txLine high when flag rises", int'(txLine), 1);
        repeat (bitCyc / 2) @(negedge clk);
        fr[10] = txLine;
        check("R2 start bit", int'(fr[0]), 0);
        check("R2 stop bit", int'(fr[10]), 1);
        if (txQ.size() == 0) begin
          check("R5 unexpected extra frame", int'(fr[9:1]), -1);
        end else begin
          logic [8:0] exp;
          exp = txQ.pop_front();
          check("R2 data and ninth bit", int'(fr[9:1]), int'(exp));
        end
        framesSeen++;
      end
    end
  end

  // receive driver: glitchBit selects a frame bit disturbed for one tick period
  task automatic sendRx(input logic [7:0] d, input logic b9, input logic stopBit, input int glitchBit);
    logic [10:0] fr;
    fr = {stopBit, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < bitCyc; c++) begin
        rxLine = fr[i] ^ ((i == glitchBit) && (c >= 8 * tickCyc) && (c < 9 * tickCyc));
        @(negedge clk);
      end
    end
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clearRx();
    rxFlagClr = 1'b1;
    @(negedge clk);
    rxFlagClr = 1'b0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txLine idle", int'(txLine), 1);
    check("R1 txFlag reset", int'(txFlag), 0);
    check("R1 rxFlag reset", int'(rxFlag), 0);
    check("R1 rxData reset", int'(rxData), 0);
    check("R1 rxBit9 reset", int'(rxBit9), 0);
    repeat (2 * bitCyc) @(negedge clk);

    // transmit at the normal rate
    sendTx(8'hA5, 1'b1, 1'b0);
    sendTx(8'h3C, 1'b0, 1'b0);
    sendTx(8'h00, 1'b0, 1'b0);
    sendTx(8'hFF, 1'b1, 1'b1);   // R5 write during frame
    check("R1 txLine high between frames", int'(txLine), 1);

    // doubled rate
    setRate(1'b1);
    sendTx(8'h5A, 1'b0, 1'b0);
    sendTx(8'hC3, 1'b1, 1'b0);
    setRate(1'b0);

    // receive
    rxEnable = 1'b1;
    sendRx(8'h96, 1'b1, 1'b1, -1);
    check("R6 rxFlag set", int'(rxFlag), 1);
    check("R6 rxData", int'(rxData), 8'h96);
    check("R6 rxBit9", int'(rxBit9), 1);
    repeat (40) @(negedge clk);
    check("R10 rxFlag holds", int'(rxFlag), 1);
    clearRx();
    check("R10 rxFlag cleared", int'(rxFlag), 0);

    // R11 one-tick glitches on a data bit and on the ninth bit
    sendRx(8'h0F, 1'b0, 1'b1, 3);
    check("R11 glitch on data bit", int'(rxData), 8'h0F);
    clearRx();
    sendRx(8'hB4, 1'b1, 1'b1, 9);
    check("R11 glitch on ninth bit", int'(rxBit9), 1);
    check("R11 data with ninth-bit glitch", int'(rxData), 8'hB4);
    clearRx();

    // R7 false start
    rxLine = 1'b0;
    repeat (3 * tickCyc) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * bitCyc) @(negedge clk);
    check("R7 no flag after false start", int'(rxFlag), 0);
    check("R7 data kept after false start", int'(rxData), 8'hB4);
    sendRx(8'h81, 1'b1, 1'b1, -1);
    check("R7 frame after false start", int'(rxData), 8'h81);
    check("R7 flag after false start", int'(rxFlag), 1);

    // R9 frame arriving while flag still set
    sendRx(8'h22, 1'b0, 1'b1, -1);
    check("R9 data kept while flag set", int'(rxData), 8'h81);
    check("R9 ninth bit kept while flag set", int'(rxBit9), 1);
    clearRx();

    // R9 stop bit low
    sendRx(8'h44, 1'b0, 1'b0, -1);
    repeat (bitCyc) @(negedge clk);
    check("R9 no flag on bad stop", int'(rxFlag), 0);
    check("R9 data kept on bad stop", int'(rxData), 8'h81);

    // R8 disabled receiver
    rxEnable = 1'b0;
    sendRx(8'h55, 1'b0, 1'b1, -1);
    check("R8 no flag while disabled", int'(rxFlag), 0);
    check("R8 data kept while disabled", int'(rxData), 8'h81);
    check("R8 ninth bit kept while disabled", int'(rxBit9), 1);
    rxEnable = 1'b1;
    repeat (bitCyc) @(negedge clk);
    sendRx(8'h6B, 1'b0, 1'b1, -1);
    check("R6 data after re-enable", int'(rxData), 8'h6B);
    check("R6 ninth bit after re-enable", int'(rxBit9), 0);
    clearRx();

    // R3 receive at doubled rate
    setRate(1'b1);
    sendRx(8'hE7, 1'b1, 1'b1, -1);
    check("R3 receive at doubled rate", int'(rxData), 8'hE7);
    check("R3 flag at doubled rate", int'(rxFlag), 1);
    clearRx();

    repeat (bitCyc) @(negedge clk);
    check("R5 frames seen", framesSeen, 6);
    check("R5 queue drained", txQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule